// File: doc/BRIEF.md
# Indirect Register Access Port

This block lets a byte-wide host bus reach a bank of 16-bit internal registers through a window of four direct byte addresses. Offset 0 holds the register index, a pin-function select bit and a read-only ready flag. Offset 1 belongs to a neighbouring interrupt block; this port returns zero there and ignores writes. Offsets 2 and 3 carry the low and high data bytes.

The host first loads the index. It then writes the low byte, which is only staged, and then the high byte. The high-byte write commits the full 16-bit word to the indexed register. Reads of offsets 2 and 3 return the bytes of the register the index currently selects.

After each commit the ready flag drops for a fixed number of cycles. A high-byte write that arrives while ready is low is not lost. It is held, with the index and staged low byte it saw, and it commits as soon as the busy window ends.

Top module: `indirect_reg_port`

## Requirements
- R1: While reset is asserted, and for BUSY_CYC cycles after it is released, offset 0 reads 0x00. After that it reads 0x80.
- R2: A write to offset 0 loads the index from bits 5:0 and the select bit from bit 6. Bit 7 of the written value is ignored. A read of offset 0 returns {ready, select, index}.
- R3: The `pin_mode` output follows the select bit from the clock edge after it is written. 0 selects the serial-audio data/clock pin pair and 1 selects the volume-button pin pair.
- R4: A write to offset 2 only stages the low byte. The indexed register reads back unchanged afterwards.
- R5: A write to offset 3 while ready is 1 stores {written byte, staged low byte} into the indexed register. The new value reads back from the next cycle on.
- R6: After a commit, ready reads 0 for exactly BUSY_CYC cycles and then returns to 1.
- R7: A write to offset 3 while ready is 0 is held, together with the index and staged low byte present at that write. It commits in the first cycle in which the busy count has expired. Ready stays 0 until then, and is 0 again for BUSY_CYC cycles after that commit.
- R8: A write to offset 3 with no low-byte write since the previous commit reuses the staged low byte.
- R9: A write to offset 0 does not disturb the staged low byte.
- R10: Offset 1 always reads 0x00. Writes to offset 1 change neither the index, the select bit nor any register.
- R11: A second offset-3 write that arrives while one is already held replaces the held write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Host access strobe for this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Direct window offset |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte for the current offset |
| pin_mode | output | 1 | Pin-function select (0 serial-audio pair, 1 volume-button pair) |

## Verification
The bench uses the default build: IDX_W = 6 and BUSY_CYC = 2. The two-cycle busy window is short enough that a high-byte write issued on the cycle after a commit falls inside it. This makes a held write, a replacement of that held write, and an index change racing the deferred commit all reachable within a few cycles. Each of these is checked cycle by cycle through the ready bit and through readback.

// File: rtl/indirect_reg_port.sv
module indirect_reg_port #(
  parameter int IDX_W    = 6,
  parameter int BUSY_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic       acc_we,
  input  logic [1:0] acc_addr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  output logic       pin_mode
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 2);
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_GAP  = 2'd1;
  localparam logic [1:0] OFS_LO   = 2'd2;
  localparam logic [1:0] OFS_HI   = 2'd3;

  logic [15:0]      bank [DEPTH];
  logic [IDX_W-1:0] idx;
  logic             sel;
  logic [7:0]       lo_stage;
  logic [CNT_W-1:0] cnt;
  logic             pend_v;
  logic [IDX_W-1:0] pend_idx;
  logic [15:0]      pend_word;

  logic wr_ctrl, wr_lo, wr_hi, rdy, commit_now, commit_pend, commit;
  logic [IDX_W-1:0] cm_idx;
  logic [15:0]      cm_word;
  logic [5:0]       idx_field;

  assign wr_ctrl     = acc_en && acc_we && acc_addr == OFS_CTRL;
  assign wr_lo       = acc_en && acc_we && acc_addr == OFS_LO;
  assign wr_hi       = acc_en && acc_we && acc_addr == OFS_HI;
  assign rdy         = cnt == '0 && !pend_v;
  assign commit_now  = wr_hi && rdy;
  assign commit_pend = pend_v && cnt == '0;
  assign commit      = commit_now || commit_pend;
  assign cm_idx      = commit_pend ? pend_idx  : idx;
  assign cm_word     = commit_pend ? pend_word : {acc_wdata, lo_stage};
  assign idx_field   = 6'(idx);
  assign pin_mode    = sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      sel <= 1'b0;
    end else if (wr_ctrl) begin
      idx <= acc_wdata[IDX_W-1:0];
      sel <= acc_wdata[6];
    end
  end

  always_ff @(posedge clk)
    if (wr_lo) lo_stage <= acc_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= CNT_W'(BUSY_CYC);
    else if (commit)   cnt <= CNT_W'(BUSY_CYC);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
    end else begin
      if (commit_pend) pend_v <= 1'b0;
      if (wr_hi && !rdy) begin
        pend_v    <= 1'b1;
        pend_idx  <= idx;
        pend_word <= {acc_wdata, lo_stage};
      end
    end
  end

  always_ff @(posedge clk)
    if (commit) bank[cm_idx] <= cm_word;

  always_comb begin
    unique case (acc_addr)
      OFS_CTRL: acc_rdata = {rdy, sel, idx_field};
      OFS_GAP:  acc_rdata = 8'h00;
      OFS_LO:   acc_rdata = bank[idx][7:0];
      default:  acc_rdata = bank[idx][15:8];
    endcase
  end
endmodule

module indirect_reg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic       acc_we,
  input logic [1:0] acc_addr,
  input logic [7:0] acc_wdata,
  input logic [7:0] acc_rdata,
  input logic       pin_mode,
  input logic       rdy,
  input logic       commit,
  input logic       pend_v
);
  assert_mode_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_addr == 2'd0) |=> pin_mode == $past(acc_wdata[6]));

  assert_busy_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !rdy);

  assert_held_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_addr == 2'd3 && !rdy) |=> (pend_v && !rdy));

  assert_low_only_stages_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_addr == 2'd2 && !pend_v) |-> !commit);

  assert_ready_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && acc_addr == 2'd0) |-> acc_rdata[7] == rdy);

  assert_gap_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && acc_addr == 2'd1) |-> acc_rdata == 8'h00);
endmodule

bind indirect_reg_port indirect_reg_port_chk u_chk (.*);

// File: tb/sim_indirect_reg_port.sv
module sim_indirect_reg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic       acc_we = 1'b0;
  logic [1:0] acc_addr = 2'd0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic       pin_mode;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  indirect_reg_port #(.IDX_W(6), .BUSY_CYC(2)) u0 (.*);

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic chk_mode(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (pin_mode !== e) begin
      errors++;
      $display("FAIL %s pin_mode actual=%0b expected=%0b", t, pin_mode, e);
    end
  endtask

  always @(negedge clk) begin
    if (acc_en && !acc_we && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (acc_rdata !== e) begin
        errors++;
        $display("FAIL %s rdata actual=%02h expected=%02h", t, acc_rdata, e);
      end
    end
  end

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rd(2'd0, 8'h00, "R1");
    rd(2'd0, 8'h00, "R1");
    @(posedge clk); #1; rst_n = 1'b1;
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = 2'd0;
    exp_q.push_back(8'h00); tag_q.push_back("R1");
    rd(2'd0, 8'h00, "R1");
    rd(2'd0, 8'h80, "R1");

    wr(2'd0, 8'h45);
    rd(2'd0, 8'hC5, "R2");
    chk_mode(1'b1, "R3");
    wr(2'd0, 8'h05);
    rd(2'd0, 8'h85, "R2");
    chk_mode(1'b0, "R3");

    wr(2'd2, 8'h11);
    wr(2'd3, 8'h22);
    rd(2'd0, 8'h05, "R6");
    rd(2'd0, 8'h05, "R6");
    rd(2'd0, 8'h85, "R6");
    rd(2'd2, 8'h11, "R5");
    rd(2'd3, 8'h22, "R5");

    wr(2'd2, 8'h77);
    rd(2'd2, 8'h11, "R4");
    rd(2'd3, 8'h22, "R4");

    wr(2'd0, 8'h05);
    wr(2'd3, 8'h99);
    wr(2'd0, 8'h87);
    rd(2'd0, 8'h07, "R2");
    rd(2'd0, 8'h87, "R6");
    wr(2'd0, 8'h05);
    rd(2'd2, 8'h77, "R9");
    rd(2'd3, 8'h99, "R9");

    wr(2'd3, 8'hAB);
    idle(); idle();
    rd(2'd2, 8'h77, "R8");
    rd(2'd3, 8'hAB, "R8");

    wr(2'd0, 8'h07);
    wr(2'd2, 8'h10);
    wr(2'd3, 8'h20);
    wr(2'd3, 8'h40);
    rd(2'd0, 8'h07, "R7");
    wr(2'd2, 8'h55);
    wr(2'd0, 8'h09);
    rd(2'd0, 8'h09, "R7");
    rd(2'd0, 8'h89, "R7");
    wr(2'd0, 8'h07);
    rd(2'd2, 8'h10, "R7");
    rd(2'd3, 8'h40, "R7");

    wr(2'd3, 8'h01);
    wr(2'd3, 8'h02);
    wr(2'd3, 8'h03);
    rd(2'd3, 8'h01, "R11");
    rd(2'd3, 8'h03, "R11");
    rd(2'd2, 8'h55, "R11");
    idle();

    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h00, "R10");
    rd(2'd0, 8'h87, "R10");
    rd(2'd3, 8'h03, "R10");
    chk_mode(1'b0, "R10");
    idle();
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule